// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt bookkeeping for a single processor core across 256 vectors. Interrupt sources assert a vector number together with a trigger flag (edge or level). The block records the vector as pending. It compares the best pending vector with a priority floor, and raises a request line to the core when that vector is allowed through.

The core takes an interrupt by pulsing an acknowledge strobe. In the same cycle it receives either the granted vector, which moves from pending to in-service, or a programmable spurious vector when nothing can be delivered. When the handler writes the end-of-interrupt register, the highest in-service vector is retired. If that vector was level-triggered, a one-cycle broadcast pulse carrying its number is sent, so that the upstream source can re-arm.

Software sets the task priority and the spurious/enable register, and can inspect the state arrays, through a small indexed register port.

Top module: `vprio_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger-mode arrays are empty, the task priority is 0, the spurious register reads 0x0FF, the request line is low, no broadcast is active and the error flag is clear.
- R2: A valid source assertion sets the vector's pending bit. It sets the vector's trigger-mode bit when the level flag is 1 and clears it when the flag is 0. Assertions from several sources in one cycle are all latched. Asserting a vector that is already pending leaves a single pending entry. When two sources name the same vector in one cycle, the higher-numbered source's flag decides the trigger-mode bit.
- R3: The processor priority equals the task priority when the task priority's bits 7:4 are greater than or equal to bits 7:4 of the highest in-service vector. Otherwise it equals that in-service class followed by four zero bits. An empty in-service array counts as vector 0.
- R4: The request line is low whenever spurious-register bit 8 (software enable) is 0 or nothing is pending.
- R5: When the processor priority is nonzero and bits 7:4 of the highest pending vector are less than or equal to its bits 7:4, the request is low. An acknowledge then returns spurious-register bits 7:0 and changes no pending or in-service bit.
- R6: An acknowledge while the request is high returns the highest pending vector in the same cycle. At the clock edge it clears that vector's pending bit and sets its in-service bit.
- R7: A write to the end-of-interrupt register clears the highest set in-service bit. In the cycle after the write, the broadcast output pulses for one cycle carrying that vector, provided its trigger-mode bit is set and spurious-register bit 12 (broadcast suppress) is 0. With an empty in-service array the write does nothing.
- R8: Writes to the spurious register keep bits 12 and 8:0 only. Writes to the processor-priority register and to the pending, in-service and trigger-mode words are ignored.
- R9: The register index is address bits 11:4. Task priority is at 0x08, processor priority at 0x0A, end-of-interrupt at 0x0B and spurious at 0x0F. In-service words are at 0x10-0x17, trigger-mode words at 0x18-0x1F and pending words at 0x20-0x27. Word n bit i is vector 32n+i. Read data appears in the cycle after the read strobe.
- R10: A read or write to any other index sets a sticky illegal-address error flag, which only reset clears.
- R11: Priority is numeric: among several pending vectors, the highest-numbered one is granted first. Among in-service vectors, the highest-numbered one is retired first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NUM_SRC | Per-source assertion strobe |
| src_vec | input | NUM_SRC*8 | Per-source vector number, source s at bits 8s+7:8s |
| src_level | input | NUM_SRC | Per-source trigger flag, 1 = level |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector returned for an acknowledge in the same cycle |
| intr_req | output | 1 | Interrupt request to the core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register address, index in bits 11:4 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| reg_err | output | 1 | Sticky illegal-address flag |
| eoi_bcast_valid | output | 1 | One-cycle end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The bench builds the block with its default 256 vectors and two sources, so every vector in every class can be swept. Each vector is taken through assertion, word readback, acknowledge, processor-priority readback and retirement, with the trigger flag varied across the sweep. On top of that sweep, directed sequences cover class-level blocking by task priority and by in-service vectors, simultaneous and duplicate assertions, the enable and suppress bits, and illegal indices.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
  localparam int unsigned IDX_LSB      = 4;
  localparam int unsigned IDX_W        = 8;
  localparam logic [7:0]  IDX_TPR      = 8'h08;
  localparam logic [7:0]  IDX_PPR      = 8'h0A;
  localparam logic [7:0]  IDX_EOI      = 8'h0B;
  localparam logic [7:0]  IDX_SVR      = 8'h0F;
  localparam logic [4:0]  GRP_ISR      = 5'b00010;
  localparam logic [4:0]  GRP_TMR      = 5'b00011;
  localparam logic [4:0]  GRP_IRR      = 5'b00100;
  localparam int unsigned SVR_W        = 13;
  localparam int unsigned SVR_EN_BIT   = 8;
  localparam int unsigned SVR_SUPP_BIT = 12;
endpackage

// File: rtl/vprio_hi_enc.sv
module vprio_hi_enc #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned NW     = NUM_VEC / WORD_W,
  localparam int unsigned IW     = $clog2(NUM_VEC),
  localparam int unsigned BW     = $clog2(WORD_W)
) (
  input  logic [NUM_VEC-1:0] vec,
  output logic               any,
  output logic [IW-1:0]      idx
);
  logic [NW-1:0]         wany;
  logic [NW-1:0][BW-1:0] widx;

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_comb begin
      wany[w] = |vec[w*WORD_W +: WORD_W];
      widx[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (vec[w*WORD_W + b]) widx[w] = BW'(b);
    end
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int w = 0; w < NW; w++)
      if (wany[w]) begin
        any = 1'b1;
        idx = IW'(w * WORD_W) + IW'(widx[w]);
      end
  end

  always_comb begin
    if (any) begin
      AST_HI_IS_TOP: assert (vec[idx] && ((vec >> idx) == NUM_VEC'(1))) else $error("encoder not on top bit"); // R11
    end
  end
endmodule

// File: rtl/vprio_vec_bank.sv
module vprio_vec_bank #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned IW     = $clog2(NUM_VEC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_valid,
  input  logic [NUM_SRC*IW-1:0] src_vec,
  input  logic [NUM_SRC-1:0]    src_level,
  input  logic                  ack_en,
  input  logic [IW-1:0]         ack_idx,
  input  logic                  eoi_en,
  input  logic [IW-1:0]         eoi_idx,
  output logic [NUM_VEC-1:0]    irr_q,
  output logic [NUM_VEC-1:0]    isr_q,
  output logic [NUM_VEC-1:0]    tmr_q
);
  logic [NUM_VEC-1:0] set_mask, tmr_n, ack_mask, eoi_mask;

  always_comb begin
    set_mask = '0;
    tmr_n    = tmr_q;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_valid[s]) begin
        set_mask[src_vec[s*IW +: IW]] = 1'b1;
        tmr_n[src_vec[s*IW +: IW]]    = src_level[s];
      end
    ack_mask = ack_en ? (NUM_VEC'(1) << ack_idx) : '0;
    eoi_mask = eoi_en ? (NUM_VEC'(1) << eoi_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_mask) | set_mask;
      isr_q <= (isr_q & ~eoi_mask) | ack_mask;
      tmr_q <= tmr_n;
    end
  end

  AST_SRC_LATCHED: assert property (@(posedge clk) disable iff (rst) (|src_valid) |=> (|irr_q)) else $error("assertion lost"); // R2
  AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (rst) (ack_en && !eoi_en) |=> isr_q[$past(ack_idx)]) else $error("ack not in service"); // R6
endmodule

// File: rtl/vprio_regfile.sv
module vprio_regfile
  import vprio_pkg::*;
#(
  parameter int unsigned NUM_VEC   = 256,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter logic [SVR_W-1:0] SVR_MASK  = 13'h11FF,
  parameter logic [SVR_W-1:0] SVR_RESET = 13'h00FF,
  localparam int unsigned NW = NUM_VEC / WORD_W,
  localparam int unsigned IW = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [IW-1:0]      ppr,
  input  logic [NUM_VEC-1:0] irr_v,
  input  logic [NUM_VEC-1:0] isr_v,
  input  logic [NUM_VEC-1:0] tmr_v,
  output logic [IW-1:0]      tpr_q,
  output logic [SVR_W-1:0]   svr_q,
  output logic               eoi_wr,
  output logic [DATA_W-1:0]  rdata_q,
  output logic               err_q
);
  logic [IDX_W-1:0]  idx;
  logic              is_isr, is_tmr, is_irr, known;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [WORD_W-1:0] word_of(input logic [NUM_VEC-1:0] v, input logic [2:0] w);
    word_of = '0;
    for (int i = 0; i < NW; i++)
      if (w == i[2:0]) word_of = v[i*WORD_W +: WORD_W];
  endfunction

  always_comb begin
    idx    = reg_addr[IDX_LSB +: IDX_W];
    is_isr = idx[7:3] == GRP_ISR;
    is_tmr = idx[7:3] == GRP_TMR;
    is_irr = idx[7:3] == GRP_IRR;
    known  = is_isr || is_tmr || is_irr || idx == IDX_TPR || idx == IDX_PPR ||
             idx == IDX_EOI || idx == IDX_SVR;
    eoi_wr = reg_wr && idx == IDX_EOI;
    rd_mux = '0;
    if (idx == IDX_TPR)      rd_mux = DATA_W'(tpr_q);
    else if (idx == IDX_PPR) rd_mux = DATA_W'(ppr);
    else if (idx == IDX_SVR) rd_mux = DATA_W'(svr_q);
    else if (is_isr)         rd_mux = DATA_W'(word_of(isr_v, idx[2:0]));
    else if (is_tmr)         rd_mux = DATA_W'(word_of(tmr_v, idx[2:0]));
    else if (is_irr)         rd_mux = DATA_W'(word_of(irr_v, idx[2:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q   <= '0;
      svr_q   <= SVR_RESET;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (reg_wr && idx == IDX_TPR) tpr_q <= reg_wdata[IW-1:0];
      if (reg_wr && idx == IDX_SVR) svr_q <= reg_wdata[SVR_W-1:0] & SVR_MASK;
      if (reg_rd) rdata_q <= rd_mux;
      if ((reg_wr || reg_rd) && !known) err_q <= 1'b1;
    end
  end

  AST_SVR_KEEP: assert property (@(posedge clk) disable iff (rst) (reg_wr && idx == IDX_SVR) |=> svr_q == ($past(reg_wdata[SVR_W-1:0]) & SVR_MASK)) else $error("svr write"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q) else $error("err dropped"); // R10
endmodule

// File: rtl/vprio_ctrl.sv
module vprio_ctrl
  import vprio_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter logic [SVR_W-1:0] SVR_MASK  = 13'h11FF,
  parameter logic [SVR_W-1:0] SVR_RESET = 13'h00FF,
  localparam int unsigned VEC_W = $clog2(NUM_VEC),
  localparam int unsigned CLS_W = VEC_W - 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       src_valid,
  input  logic [NUM_SRC*VEC_W-1:0] src_vec,
  input  logic [NUM_SRC-1:0]       src_level,
  input  logic                     ack,
  output logic [VEC_W-1:0]         ack_vec,
  output logic                     intr_req,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     reg_err,
  output logic                     eoi_bcast_valid,
  output logic [VEC_W-1:0]         eoi_bcast_vec
);
  logic [NUM_VEC-1:0] irr_v, isr_v, tmr_v;
  logic               irr_any, isr_any, eoi_wr, ack_en, eoi_en, blocked;
  logic [VEC_W-1:0]   irr_hi, isr_hi, tpr, ppr;
  logic [SVR_W-1:0]   svr;
  logic [CLS_W-1:0]   isr_cls;

  vprio_hi_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) irr_enc_i (.vec(irr_v), .any(irr_any), .idx(irr_hi));
  vprio_hi_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) isr_enc_i (.vec(isr_v), .any(isr_any), .idx(isr_hi));

  always_comb begin
    isr_cls  = isr_any ? isr_hi[VEC_W-1:4] : '0;
    ppr      = (tpr[VEC_W-1:4] >= isr_cls) ? tpr : {isr_cls, 4'h0};
    blocked  = (ppr != '0) && (irr_hi[VEC_W-1:4] <= ppr[VEC_W-1:4]);
    intr_req = svr[SVR_EN_BIT] && irr_any && !blocked;
    ack_vec  = intr_req ? irr_hi : svr[VEC_W-1:0];
    ack_en   = ack && intr_req;
    eoi_en   = eoi_wr && isr_any;
  end

  vprio_vec_bank #(.NUM_VEC(NUM_VEC), .NUM_SRC(NUM_SRC)) bank_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_vec(src_vec), .src_level(src_level),
    .ack_en(ack_en), .ack_idx(irr_hi), .eoi_en(eoi_en), .eoi_idx(isr_hi),
    .irr_q(irr_v), .isr_q(isr_v), .tmr_q(tmr_v)
  );

  vprio_regfile #(
    .NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SVR_MASK(SVR_MASK), .SVR_RESET(SVR_RESET)
  ) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ppr(ppr), .irr_v(irr_v), .isr_v(isr_v), .tmr_v(tmr_v),
    .tpr_q(tpr), .svr_q(svr), .eoi_wr(eoi_wr), .rdata_q(reg_rdata), .err_q(reg_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_bcast_valid <= 1'b0;
      eoi_bcast_vec   <= '0;
    end else begin
      eoi_bcast_valid <= eoi_en && tmr_v[isr_hi] && !svr[SVR_SUPP_BIT];
      eoi_bcast_vec   <= isr_hi;
    end
  end

  AST_BCAST_CAUSE: assert property (@(posedge clk) disable iff (rst) eoi_bcast_valid |-> $past(eoi_wr && isr_any)) else $error("stray broadcast"); // R7
  AST_BLOCKED_ACK: assert property (@(posedge clk) disable iff (rst) (ack && !intr_req && !eoi_wr) |=> isr_v == $past(isr_v)) else $error("blocked ack moved state"); // R5
  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (rst) ppr >= tpr) else $error("ppr below tpr"); // R3
  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (rst) !svr[SVR_EN_BIT] |-> !intr_req) else $error("req while disabled"); // R4
endmodule

// File: tb/vprio_ctrl_tb_top.sv
module vprio_ctrl_tb_top;
  localparam int unsigned NS = 2;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NS-1:0]   src_valid = '0;
  logic [NS*8-1:0] src_vec = '0;
  logic [NS-1:0]   src_level = '0;
  logic        ack = 1'b0;
  logic [7:0]  ack_vec;
  logic        intr_req;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err, eoi_bcast_valid;
  logic [7:0]  eoi_bcast_vec;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vprio_ctrl dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_vec(src_vec), .src_level(src_level),
    .ack(ack), .ack_vec(ack_vec), .intr_req(intr_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = {idx, 4'h0}; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = {idx, 4'h0};
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl);
    src_valid = 2'b01; src_vec = {8'h00, v}; src_level = {1'b0, lvl};
    tick();
    src_valid = '0;
  endtask

  task automatic raise2(input logic [7:0] v0, input logic l0, input logic [7:0] v1, input logic l1);
    src_valid = 2'b11; src_vec = {v1, v0}; src_level = {l1, l0};
    tick();
    src_valid = '0;
  endtask

  task automatic take(output logic [7:0] v);
    ack = 1'b1;
    #1 v = ack_vec;
    tick();
    ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [7:0]  v;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", intr_req, 0);
    chk("R1 bcast", eoi_bcast_valid, 0);
    chk("R1 err", reg_err, 0);
    rd(8'h08, d); chk("R1 tpr", d, 0);
    rd(8'h0F, d); chk("R1 svr", d, 32'h0FF);
    rd(8'h0A, d); chk("R1 ppr", d, 0);
    for (int w = 0; w < 8; w++) begin
      rd(8'h20 + 8'(w), d); chk("R1 irr", d, 0);
      rd(8'h10 + 8'(w), d); chk("R1 isr", d, 0);
    end
    wr(8'h0F, 32'h1FF);
    // sweep all vectors: R2 R3 R6 R7 R9
    for (int i = 0; i < 256; i++) begin
      logic lvl;
      logic [31:0] bit_m;
      lvl = (i % 3 == 0);
      bit_m = 32'h1 << (i % 32);
      raise(8'(i), lvl);
      chk("R4 req on pending", intr_req, 1);
      rd(8'h20 + 8'(i / 32), d); chk("R9 irr word", d, bit_m);
      rd(8'h18 + 8'(i / 32), d); chk("R2 tmr bit", (d >> (i % 32)) & 1, 32'(lvl));
      take(v); chk("R6 ack vec", v, i);
      chk("R6 req after ack", intr_req, 0);
      rd(8'h10 + 8'(i / 32), d); chk("R6 isr word", d, bit_m);
      rd(8'h20 + 8'(i / 32), d); chk("R6 irr cleared", d, 0);
      rd(8'h0A, d); chk("R3 ppr", d, ((i >> 4) == 0) ? 0 : (i & 32'hF0));
      wr(8'h0B, 0);
      chk("R7 bcast", eoi_bcast_valid, 32'(lvl));
      if (lvl) chk("R7 bcast vec", eoi_bcast_vec, i);
      rd(8'h10 + 8'(i / 32), d); chk("R7 isr retired", d, 0);
    end
    // R11 ordering within class 0
    raise(2, 0); raise(14, 0); raise(7, 0); raise(9, 1);
    take(v); chk("R11 first", v, 14);
    take(v); chk("R11 second", v, 9);
    take(v); chk("R11 third", v, 7);
    take(v); chk("R11 fourth", v, 2);
    wr(8'h0B, 0); chk("R7 edge no bcast", eoi_bcast_valid, 0);
    rd(8'h10, d); chk("R11 eoi highest", d, 32'h284);
    wr(8'h0B, 0); chk("R7 level bcast", eoi_bcast_valid, 1); chk("R11 eoi vec", eoi_bcast_vec, 9);
    wr(8'h0B, 0); wr(8'h0B, 0);
    rd(8'h10, d); chk("R7 isr empty", d, 0);
    // R2 two sources at once
    raise2(10, 0, 200, 1);
    take(v); chk("R2 both latched hi", v, 200);
    chk("R5 blocked req", intr_req, 0);
    take(v); chk("R5 spurious", v, 8'hFF);
    rd(8'h20, d); chk("R5 irr unchanged", d, 32'h400);
    rd(8'h16, d); chk("R5 isr unchanged", d, 32'h100);
    wr(8'h0B, 0); chk("R7 bcast 200", eoi_bcast_vec, 200);
    take(v); chk("R2 both latched lo", v, 10);
    wr(8'h0B, 0); chk("R7 edge 10", eoi_bcast_valid, 0);
    // R2 same vector, both sources
    raise2(77, 0, 77, 1);
    rd(8'h1A, d); chk("R2 higher source flag", (d >> 13) & 1, 1);
    take(v); chk("R2 dup vec", v, 77);
    chk("R2 single entry", intr_req, 0);
    wr(8'h0B, 0); chk("R7 bcast 77", eoi_bcast_valid, 1);
    raise(77, 0); raise(77, 0);
    take(v); chk("R2 dup again", v, 77);
    chk("R2 single entry edge", intr_req, 0);
    wr(8'h0B, 0); chk("R2 edge clears tmr", eoi_bcast_valid, 0);
    // R3 R5 task priority
    wr(8'h08, 32'h50);
    rd(8'h0A, d); chk("R3 ppr tpr", d, 32'h50);
    raise(8'h55, 0);
    chk("R5 tpr blocks", intr_req, 0);
    take(v); chk("R5 tpr spurious", v, 8'hFF);
    raise(8'h60, 0);
    chk("R5 above class", intr_req, 1);
    take(v); chk("R6 60", v, 8'h60);
    rd(8'h0A, d); chk("R3 ppr isr", d, 32'h60);
    wr(8'h08, 32'h7A);
    rd(8'h0A, d); chk("R3 ppr tpr wins", d, 32'h7A);
    rd(8'h08, d); chk("R9 tpr read", d, 32'h7A);
    wr(8'h0B, 0);
    chk("R5 still blocked", intr_req, 0);
    wr(8'h08, 0);
    chk("R5 unblocked", intr_req, 1);
    take(v); chk("R6 55", v, 8'h55);
    wr(8'h0B, 0);
    // R4 software enable, R7 suppress
    wr(8'h0F, 32'h0AB);
    raise(8'h90, 1);
    chk("R4 disabled", intr_req, 0);
    take(v); chk("R4 spurious", v, 8'hAB);
    rd(8'h24, d); chk("R4 still pending", d, 32'h10000);
    wr(8'h0F, 32'h11AB);
    chk("R4 enabled", intr_req, 1);
    take(v); chk("R6 90", v, 8'h90);
    wr(8'h0B, 0); chk("R7 suppressed", eoi_bcast_valid, 0);
    rd(8'h14, d); chk("R7 suppressed retire", d, 0);
    rd(8'h0F, d); chk("R8 svr read", d, 32'h11AB);
    wr(8'h0F, 32'hFFFF_FFFF);
    rd(8'h0F, d); chk("R8 svr mask", d, 32'h11FF);
    wr(8'h0F, 32'h1FF);
    // R7 empty eoi
    wr(8'h0B, 0); chk("R7 empty eoi", eoi_bcast_valid, 0);
    // R8 ignored writes
    rd(8'h1A, d2);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h13, 32'hFFFF_FFFF);
    wr(8'h1A, 32'h0); wr(8'h0A, 32'hF0);
    rd(8'h20, d); chk("R8 irr ro", d, 0);
    rd(8'h13, d); chk("R8 isr ro", d, 0);
    rd(8'h1A, d); chk("R8 tmr ro", d, d2);
    rd(8'h0A, d); chk("R8 ppr ro", d, 0);
    chk("R8 no req", intr_req, 0);
    chk("R10 known no err", reg_err, 0);
    // R10 unknown index
    rd(8'h40, d); chk("R10 err set", reg_err, 1);
    wr(8'h01, 0); tick(); chk("R10 err sticky", reg_err, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule